// File: doc/BRIEF.md
# Shared Tagged Receive Queue for a Four-Line Serial Controller

This block collects received characters from four asynchronous serial lines into one shared first-in first-out queue. Each line's deserialiser, which sits outside the block, presents a completed character together with its parity-error and framing-error flags. The block tags every stored character with the number of the line it came from, so software can drain all four lines through a single read port.

A read strobe pops the head entry into a 16-bit read word. The word carries the character, the source line, the per-character error flags, an overrun marker and a valid bit. The block keeps three outputs up to date: a status bit that is high while the queue holds data, a receive interrupt request, and a lost-character marker. The marker is carried on the next character the queue stores.

A three-bit control word drives the block:

- bit 0 enables line scanning.
- bit 1 enables the receive interrupt.
- bit 2 is a master clear.

Top module: `rx_silo`

## Requirements
- R1: The queue holds exactly 64 entries. After 64 characters are stored without a read, 64 consecutive reads return valid words and the 65th read returns a word with bit 15 clear.
- R2: A valid read word carries the character in bits 7:0 and the source line number (0 to 3) in bits 9:8. Bits 11:10 always read as zero.
- R3: Bit 12 of a read word is the character's parity-error flag, bit 13 is its framing-error flag, and bit 15 marks the word as valid.
- R4: `rx_done` is high exactly while the queue holds at least one character.
- R5: `rx_irq` is high exactly when control bit 1 (interrupt enable) is set and `rx_done` is high.
- R6: While control bit 2 (master clear) is set, the block synchronously empties the queue, discards held characters, clears the pending overrun and sets `rd_word` to zero. `rst` does the same.
- R7: While control bit 0 (scan enable) is clear, incoming pushes are ignored and no held character enters the queue.
- R8: A character that reaches a full queue is dropped. Bit 14 (overrun) is then set on the next character that is stored, and on no later one.
- R9: A read strobe on an empty queue sets `rd_word` to zero, which has the valid bit clear, and pops nothing. A strobe on a non-empty queue loads the head entry with bit 15 set and pops it.
- R10: Each line has a one-character hold stage. Every cycle, the lowest-numbered occupied hold is moved into the queue, so lines that push in the same cycle are stored in ascending line order, one per cycle.
- R11: A push on a line whose hold is still occupied and is not being drained in that cycle replaces the held character. The replaced character counts as lost, as in R8.
- R12: A push sampled at clock edge t is stored at edge t+1. A read strobe sampled at edge t+1 still sees the queue without it, while a strobe at edge t+2 returns it. `rd_word` changes only on the edge that samples a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 3 | bit 0 scan enable, bit 1 receive interrupt enable, bit 2 master clear |
| push_valid | input | 4 | Per-line push request, bit i is line i |
| push_char | input | 32 | Per-line character, line i in bits 8i+7:8i |
| push_perr | input | 4 | Per-line parity-error flag |
| push_ferr | input | 4 | Per-line framing-error flag |
| rd_strobe | input | 1 | Read strobe, pops the head entry into rd_word |
| rd_word | output | 16 | Last read word |
| rx_done | output | 1 | Queue is not empty |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The embedded properties check several rules on every cycle:

- The occupancy never passes the depth.
- An empty-queue read never returns a valid word.
- A master clear always leaves the block empty and idle.
- Nothing enters the queue while scanning is off.
- A drop at a full queue always arms the overrun marker.
- The arbiter only drains occupied holds.

Other behaviour shows only in the bench's scenarios. This covers the ascending-line order of simultaneous pushes, the placement of the overrun bit on exactly the next stored character, hold-stage overwrites, the exact 64-entry limit and the two-edge push-to-read latency. The bench checks these against a cycle-level model under directed and random traffic.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;

    localparam int NUM_LINES  = 4;
    localparam int LINE_W     = 2;
    localparam int CHAR_W     = 8;
    localparam int WORD_W     = 16;

    localparam int CTL_SCAN   = 0;
    localparam int CTL_IRQ_EN = 1;
    localparam int CTL_CLEAR  = 2;

    typedef struct packed {
        logic              ferr;
        logic              perr;
        logic [CHAR_W-1:0] ch;
    } rx_in_t;

    typedef struct packed {
        logic              ovr;
        logic              ferr;
        logic              perr;
        logic [LINE_W-1:0] line;
        logic [CHAR_W-1:0] ch;
    } silo_ent_t;

    localparam int ENT_W = $bits(silo_ent_t);

    function automatic logic [WORD_W-1:0] to_word(input silo_ent_t e);
        return {1'b1, e.ovr, e.ferr, e.perr, 2'b00, e.line, e.ch};
    endfunction

endpackage

// File: rtl/rx_silo_hold.sv
module rx_silo_hold
    import rx_silo_pkg::*;
#(
    parameter int NL = NUM_LINES
) (
    input  logic                 clk,
    input  logic                 srst,
    input  logic                 scan,
    input  logic [NL-1:0]        push_v,
    input  rx_in_t [NL-1:0]      push_d,
    output logic                 sel_v,
    output silo_ent_t            sel_ent,
    output logic                 lost
);

    logic   [NL-1:0] hv;
    rx_in_t [NL-1:0] hd;
    logic   [NL-1:0] grant;

    always_comb begin
        grant   = '0;
        sel_v   = 1'b0;
        sel_ent = '0;
        if (scan) begin
            for (int i = 0; i < NL; i++) begin
                if (hv[i] && !sel_v) begin
                    grant[i]     = 1'b1;
                    sel_v        = 1'b1;
                    sel_ent.ch   = hd[i].ch;
                    sel_ent.perr = hd[i].perr;
                    sel_ent.ferr = hd[i].ferr;
                    sel_ent.line = LINE_W'(i);
                end
            end
        end
    end

    assign lost = scan && |(push_v & hv & ~grant);

    for (genvar g = 0; g < NL; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (srst) begin
                hv[g] <= 1'b0;
                hd[g] <= '0;
            end else if (scan && push_v[g]) begin
                hv[g] <= 1'b1;
                hd[g] <= push_d[g];
            end else if (grant[g]) begin
                hv[g] <= 1'b0;
            end
        end
    end

    // R10
    grant_occupied_chk: assert property (@(posedge clk) disable iff (srst)
        (grant & ~hv) == '0);

    // R7
    scan_off_idle_chk: assert property (@(posedge clk) disable iff (srst)
        !scan |-> !sel_v);

endmodule

// File: rtl/rx_silo_fifo.sv
module rx_silo_fifo
    import rx_silo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int W     = ENT_W
) (
    input  logic                     clk,
    input  logic                     srst,
    input  logic                     wr,
    input  logic [W-1:0]             wdata,
    input  logic                     rd,
    output logic [W-1:0]             head,
    output logic [$clog2(DEPTH):0]   count
);

    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_wr, do_rd;

    assign do_wr = wr && (count != (AW+1)'(DEPTH));
    assign do_rd = rd && (count != '0);
    assign head  = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_wr && !srst) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
            if (do_rd) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (srst)
        count <= (AW+1)'(DEPTH));

endmodule

// File: rtl/rx_silo.sv
module rx_silo
    import rx_silo_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [2:0]                  ctrl,
    input  logic [NUM_LINES-1:0]        push_valid,
    input  logic [NUM_LINES*CHAR_W-1:0] push_char,
    input  logic [NUM_LINES-1:0]        push_perr,
    input  logic [NUM_LINES-1:0]        push_ferr,
    input  logic                        rd_strobe,
    output logic [WORD_W-1:0]           rd_word,
    output logic                        rx_done,
    output logic                        rx_irq
);

    localparam int CW = $clog2(DEPTH) + 1;

    logic clear, scan, irq_en, srst;
    assign clear  = ctrl[CTL_CLEAR];
    assign scan   = ctrl[CTL_SCAN];
    assign irq_en = ctrl[CTL_IRQ_EN];
    assign srst   = rst || clear;

    rx_in_t [NUM_LINES-1:0] push_d;
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_in
        assign push_d[g].ch   = push_char[g*CHAR_W +: CHAR_W];
        assign push_d[g].perr = push_perr[g];
        assign push_d[g].ferr = push_ferr[g];
    end

    logic      sel_v, lost_ovw;
    silo_ent_t sel_ent, wr_ent, head_ent;
    logic [CW-1:0] count;
    logic      full, store, drop, pop, ovr_pend;

    rx_silo_hold #(.NL(NUM_LINES)) u_hold (
        .clk    (clk),
        .srst   (srst),
        .scan   (scan),
        .push_v (push_valid),
        .push_d (push_d),
        .sel_v  (sel_v),
        .sel_ent(sel_ent),
        .lost   (lost_ovw)
    );

    assign full  = (count == CW'(DEPTH));
    assign store = sel_v && !full;
    assign drop  = sel_v && full;
    assign pop   = rd_strobe && rx_done;

    always_comb begin
        wr_ent     = sel_ent;
        wr_ent.ovr = ovr_pend;
    end

    rx_silo_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
        .clk  (clk),
        .srst (srst),
        .wr   (store),
        .wdata(wr_ent),
        .rd   (pop),
        .head (head_ent),
        .count(count)
    );

    always_ff @(posedge clk) begin
        if (srst) ovr_pend <= 1'b0;
        else      ovr_pend <= (ovr_pend && !store) || drop || lost_ovw;
    end

    always_ff @(posedge clk) begin
        if (srst)           rd_word <= '0;
        else if (rd_strobe) rd_word <= pop ? to_word(head_ent) : '0;
    end

    assign rx_done = (count != '0);
    assign rx_irq  = irq_en && rx_done;

    // R9
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !rx_done && !clear) |=> !rd_word[15]);

    // R6
    clear_idle_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!rx_done && rd_word == '0));

    // R7
    scan_gate_chk: assert property (@(posedge clk) disable iff (srst)
        !scan |=> (count <= $past(count)));

    // R8
    drop_mark_chk: assert property (@(posedge clk) disable iff (srst)
        drop |=> ovr_pend);

endmodule

// File: tb/tb_rx_silo.sv
module tb_rx_silo;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  ctrl = 3'b000;
    logic [3:0]  pv = '0, pe = '0, fe = '0;
    logic [31:0] pc = '0;
    logic        rd = 1'b0;
    logic [15:0] rd_word;
    logic        rx_done, rx_irq;

    always #5 clk = ~clk;

    rx_silo dut (
        .clk(clk), .rst(rst), .ctrl(ctrl), .push_valid(pv), .push_char(pc),
        .push_perr(pe), .push_ferr(fe), .rd_strobe(rd), .rd_word(rd_word),
        .rx_done(rx_done), .rx_irq(rx_irq)
    );

    int checks = 0, fails = 0;
    string ph = "R4";

    logic [15:0] mq[$];
    logic [3:0]  hv_m = '0;
    logic [7:0]  hc_m [4];
    logic [3:0]  hpe_m = '0, hfe_m = '0;
    logic        ovr_m = 1'b0;
    logic [15:0] word_m = '0;
    int          g, n;
    logic        lost, stored;

    function automatic logic [15:0] mk(input logic o, input logic f, input logic p,
                                       input int ln, input logic [7:0] c);
        return {1'b1, o, f, p, 2'b00, 2'(ln), c};
    endfunction

    always @(posedge clk) begin
        if (rst || ctrl[2]) begin
            mq.delete(); hv_m = '0; ovr_m = 1'b0; word_m = '0;
        end else begin
            n = mq.size(); lost = 1'b0; stored = 1'b0; g = -1;
            if (rd) begin
                if (n > 0) word_m = mq.pop_front();
                else       word_m = '0;
            end
            if (ctrl[0]) begin
                for (int i = 0; i < 4; i++) if (hv_m[i] && g < 0) g = i;
                if (g >= 0) begin
                    if (n == 64) lost = 1'b1;
                    else begin
                        mq.push_back(mk(ovr_m, hfe_m[g], hpe_m[g], g, hc_m[g]));
                        stored = 1'b1;
                    end
                    hv_m[g] = 1'b0;
                end
                for (int i = 0; i < 4; i++) if (pv[i]) begin
                    if (hv_m[i]) lost = 1'b1;
                    hv_m[i] = 1'b1; hc_m[i] = pc[i*8 +: 8];
                    hpe_m[i] = pe[i]; hfe_m[i] = fe[i];
                end
            end
            ovr_m = (ovr_m && !stored) || lost;
        end
    end

    task automatic check(input logic ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [3:0] v, input logic [31:0] c, input logic [3:0] p,
                       input logic [3:0] f, input logic r);
        @(negedge clk);
        check(rd_word == word_m, ph, rd_word, word_m);
        check(rx_done == (mq.size() != 0), "R4", 16'(rx_done), 16'(mq.size() != 0));
        check(rx_irq == (ctrl[1] && mq.size() != 0), "R5", 16'(rx_irq),
              16'(ctrl[1] && mq.size() != 0));
        pv = v; pc = c; pe = p; fe = f; rd = r;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) cyc('0, '0, '0, '0, 1'b0);
    endtask

    int cyc_cnt = 0;
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000) begin
            fails++;
            $display("FAIL watchdog act=%0d exp=done", cyc_cnt);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    int vcount;

    initial begin
        void'($urandom(32'd4242));
        idle(2);
        @(negedge clk);
        check(rd_word == 16'h0 && !rx_done, "R6", rd_word, 16'h0);
        rst = 1'b0;
        ctrl = 3'b011;

        ph = "R9"; idle(1);
        cyc('0, '0, '0, '0, 1'b1); idle(1);
        check(rd_word[15] == 1'b0, "R9", rd_word, 16'h0);

        ph = "R12";
        cyc(4'b0100, 32'h00A5_0000, 4'b0100, 4'b0000, 1'b0);
        cyc('0, '0, '0, '0, 1'b1);
        cyc('0, '0, '0, '0, 1'b1);
        cyc('0, '0, '0, '0, 1'b0);
        ph = "R2";
        check(rd_word == 16'h92A5, "R3", rd_word, 16'h92A5);
        idle(1);

        ph = "R10";
        cyc(4'b1011, 32'h3300_1100, 4'b0000, 4'b1000, 1'b0);
        idle(4);
        cyc('0, '0, '0, '0, 1'b1); cyc('0, '0, '0, '0, 1'b0);
        check(rd_word == 16'h8000, "R10", rd_word, 16'h8000);
        cyc('0, '0, '0, '0, 1'b1); cyc('0, '0, '0, '0, 1'b0);
        check(rd_word == 16'h8111, "R10", rd_word, 16'h8111);
        cyc('0, '0, '0, '0, 1'b1); cyc('0, '0, '0, '0, 1'b0);
        check(rd_word == 16'hA333, "R10", rd_word, 16'hA333);

        ph = "R7"; ctrl = 3'b010;
        cyc(4'b1111, 32'hFFFF_FFFF, '0, '0, 1'b0); idle(3);
        check(!rx_done, "R7", 16'(rx_done), 16'h0);
        ctrl = 3'b011; idle(2);
        check(!rx_done, "R7", 16'(rx_done), 16'h0);

        ph = "R1";
        for (int i = 0; i < 66; i++) cyc(4'b0001, 32'(i), '0, '0, 1'b0);
        idle(2);
        vcount = 0;
        for (int i = 0; i < 65; i++) begin
            cyc('0, '0, '0, '0, 1'b1); cyc('0, '0, '0, '0, 1'b0);
            if (rd_word[15]) vcount++;
        end
        check(vcount == 64, "R1", 16'(vcount), 16'd64);
        ph = "R8";
        cyc(4'b0010, 32'h0000_5A00, '0, '0, 1'b0); idle(2);
        cyc('0, '0, '0, '0, 1'b1); cyc('0, '0, '0, '0, 1'b0);
        check(rd_word == 16'hC15A, "R8", rd_word, 16'hC15A);

        ph = "R11";
        cyc(4'b0011, 32'h0000_2010, '0, '0, 1'b0);
        cyc(4'b0011, 32'h0000_2111, '0, '0, 1'b0);
        idle(4);
        for (int i = 0; i < 4; i++) cyc('0, '0, '0, '0, 1'b1);
        cyc(4'b0100, 32'h0077_0000, '0, '0, 1'b0); idle(2);
        cyc('0, '0, '0, '0, 1'b1); cyc('0, '0, '0, '0, 1'b0);
        check(rd_word == 16'h8277, "R11", rd_word, 16'h8277);

        ph = "R6";
        for (int i = 0; i < 5; i++) cyc(4'b1000, 32'hAB00_0000, '0, '0, 1'b0);
        cyc('0, '0, '0, '0, 1'b1);
        ctrl = 3'b111; idle(1);
        ctrl = 3'b011; idle(1);
        check(!rx_done && rd_word == 16'h0, "R6", rd_word, 16'h0);

        ph = "R2";
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 99) < 3) ctrl[0] = ~ctrl[0];
            if ($urandom_range(0, 99) < 5) ctrl[1] = ~ctrl[1];
            cyc(($urandom_range(0, 99) < 40) ? 4'($urandom) : 4'b0000, $urandom,
                4'($urandom), 4'($urandom), ($urandom_range(0, 99) < 30));
        end
        ctrl[0] = 1'b1;
        for (int i = 0; i < 80; i++) cyc('0, '0, '0, '0, 1'b1);
        idle(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule